// File: doc/BRIEF.md
# Aperture Page Remapping Unit

The block translates client addresses that fall inside a fixed window (the aperture) into physical addresses. The aperture is a run of consecutive 4 KiB pages starting at a parameterised base. Each page has one table entry: a valid flag in bit 31 and a physical page address in bits 30:12. Software reaches the table indirectly. It first loads a pointer register with an aperture byte address. It then writes or reads an entry data register, which acts on the entry that the pointer selects. A single enable bit turns translation on or off.

Clients present one request address per cycle with a strobe. One cycle later the block returns either the physical address, formed from the entry's page address and the request's low 12 offset bits, or a fault. A fault is raised when the address lies outside the aperture, when the page's entry is not valid, or when translation is disabled.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, every entry reads as zero, the pointer holds the aperture base, and no response is raised.
- R2: A write to offset 0x0 loads the enable from bit 0 of the written data. A read of offset 0x0 returns that bit in bit 0, with all other bits zero.
- R3: A write to offset 0x4 loads the pointer if the written value lies in [base, base + PAGE_COUNT×4096 − 1]. Otherwise the write is ignored and the pointer keeps its value. A read of offset 0x4 returns the pointer.
- R4: A write to offset 0x8 stores bit 31 (valid) and bits 30:12 (page address) of the written data into entry (pointer − base) >> 12. A read of offset 0x8 returns that stored word, with bits 11:0 read as zero.
- R5: Writing zero through offset 0x8 unmaps the page, so the page's valid bit reads 0 and its lookups fault.
- R6: A lookup for an enabled, in-aperture address whose entry is valid gives, on the next cycle, resp_valid=1, resp_ok=1, resp_fault=0 and resp_addr = {0, entry[30:12], addr[11:0]}. A cycle without a request gives all response outputs at 0.
- R7: A lookup below the base, or at or above base + PAGE_COUNT×4096, gives resp_valid=1, resp_fault=1, resp_ok=0 and resp_addr=0 on the next cycle.
- R8: A lookup whose entry has valid=0, or any lookup made while translation is disabled, faults in the same way as R7.
- R9: When an entry write and a lookup of the same page occur in the same cycle, the lookup uses the entry as it stood before the write.
- R10: Read data appears on reg_rdata in the cycle after a read strobe and holds until the next read. Offsets other than 0x0, 0x4 and 0x8 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_off | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Client address to translate |
| resp_valid | output | 1 | Response present |
| resp_ok | output | 1 | Translation succeeded |
| resp_fault | output | 1 | Translation failed |
| resp_addr | output | 32 | Translated physical address, zero on fault |

## Verification
An entry data write and a client lookup can land in the same cycle and target the same page. The bench provokes this by driving the write and a request for that page together: once when an entry is replaced by a new page address, and once when a valid entry is cleared to zero. Its reference model computes each response from the entry as it stood before the clock edge, so the colliding lookup must return the old page address or the old hit. The lookup in the following cycle must then show the new contents.

// File: rtl/aperture_remap_pkg.sv
`timescale 1ns/1ps
package aperture_remap_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int FRAME_W    = 19;

    localparam logic [3:0] OFF_CFG   = 4'h0;
    localparam logic [3:0] OFF_EADDR = 4'h4;
    localparam logic [3:0] OFF_EDATA = 4'h8;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    function automatic logic [31:0] pte_word(pte_t p);
        return {p.valid, p.frame, 12'h000};
    endfunction

    function automatic pte_t word_pte(logic [31:12] w);
        pte_t p;
        p.valid = w[31];
        p.frame = w[30:12];
        return p;
    endfunction

    function automatic logic in_aper(logic [31:0] a, logic [31:0] base, logic [32:0] span);
        return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < ({1'b0, base} + span));
    endfunction

    function automatic logic [19:0] page_of(logic [31:0] a, logic [31:0] base);
        return 20'((a - base) >> PAGE_SHIFT);
    endfunction

endpackage

// File: rtl/remap_table.sv
`timescale 1ns/1ps
module remap_table
    import aperture_remap_pkg::*;
#(
    parameter int PAGE_COUNT = 16,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pte_t             wr_pte,
    input  logic [IDX_W-1:0] ra_idx,
    output pte_t             ra_pte,
    input  logic [IDX_W-1:0] rb_idx,
    output pte_t             rb_pte
);

    typedef struct packed {
        pte_t [PAGE_COUNT-1:0] ent;
    } tbl_s;

    tbl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_pte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ra_pte = (32'(ra_idx) < 32'(PAGE_COUNT)) ? st_q.ent[ra_idx] : '0;
    assign rb_pte = (32'(rb_idx) < 32'(PAGE_COUNT)) ? st_q.ent[rb_idx] : '0;

    AST_ZERO_UNMAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_pte.valid) |=> !st_q.ent[$past(wr_idx)].valid); // R5

endmodule

// File: rtl/remap_regs.sv
`timescale 1ns/1ps
module remap_regs
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h0800_0000,
    parameter logic [32:0] SPAN      = 33'h0_0001_0000,
    parameter int          IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [3:0]       reg_off,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             xlat_en,
    output logic             tbl_wr_en,
    output logic [IDX_W-1:0] tbl_idx,
    output pte_t             tbl_wr_pte,
    input  pte_t             tbl_rd_pte
);

    typedef struct packed {
        logic        en;
        logic [31:0] ptr;
        logic [31:0] rdata;
    } regs_s;

    regs_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        tbl_wr_en = 1'b0;
        if (reg_en && reg_we) begin
            unique case (reg_off)
                OFF_CFG:   st_d.en = reg_wdata[0];
                OFF_EADDR: if (in_aper(reg_wdata, APER_BASE, SPAN)) st_d.ptr = reg_wdata;
                OFF_EDATA: tbl_wr_en = 1'b1;
                default:   ;
            endcase
        end else if (reg_en) begin
            unique case (reg_off)
                OFF_CFG:   st_d.rdata = {31'h0, st_q.en};
                OFF_EADDR: st_d.rdata = st_q.ptr;
                OFF_EDATA: st_d.rdata = pte_word(tbl_rd_pte);
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= 1'b0;
            st_q.ptr   <= APER_BASE;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata  = st_q.rdata;
    assign xlat_en    = st_q.en;
    assign tbl_idx    = IDX_W'(page_of(st_q.ptr, APER_BASE));
    assign tbl_wr_pte = word_pte(reg_wdata[31:12]);

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_off == OFF_CFG) |=> (xlat_en == $past(reg_wdata[0]))); // R2

    AST_PTR_IN_APER: assert property (@(posedge clk) disable iff (!rst_n)
        in_aper(st_q.ptr, APER_BASE, SPAN)); // R3

endmodule

// File: rtl/remap_lookup.sv
`timescale 1ns/1ps
module remap_lookup
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h0800_0000,
    parameter logic [32:0] SPAN      = 33'h0_0001_0000,
    parameter int          IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlat_en,
    input  logic             req_valid,
    input  logic [31:0]      req_addr,
    output logic [IDX_W-1:0] tbl_idx,
    input  pte_t             tbl_pte,
    output logic             resp_valid,
    output logic             resp_ok,
    output logic             resp_fault,
    output logic [31:0]      resp_addr
);

    typedef struct packed {
        logic        valid;
        logic        ok;
        logic        fault;
        logic [31:0] addr;
    } resp_s;

    resp_s st_d, st_q;
    logic  hit;
    logic  pass;

    assign tbl_idx = IDX_W'(page_of(req_addr, APER_BASE));

    always_comb begin
        hit        = in_aper(req_addr, APER_BASE, SPAN);
        pass       = xlat_en && hit && tbl_pte.valid;
        st_d.valid = req_valid;
        st_d.ok    = req_valid && pass;
        st_d.fault = req_valid && !pass;
        st_d.addr  = (req_valid && pass) ? {1'b0, tbl_pte.frame, req_addr[11:0]} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.valid;
    assign resp_ok    = st_q.ok;
    assign resp_fault = st_q.fault;
    assign resp_addr  = st_q.addr;

    AST_RESP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_ok && !resp_fault)); // R6

    AST_OK_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_ok != resp_fault)); // R7

    AST_DISABLED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_en) |=> (resp_fault && resp_addr == 32'h0)); // R8

endmodule

// File: rtl/aperture_remap.sv
`timescale 1ns/1ps
module aperture_remap
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE  = 32'h0800_0000,
    parameter int          PAGE_COUNT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [3:0]  reg_off,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        resp_valid,
    output logic        resp_ok,
    output logic        resp_fault,
    output logic [31:0] resp_addr
);

    localparam int          IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;
    localparam logic [32:0] SPAN  = 33'(PAGE_COUNT) << PAGE_SHIFT;

    logic             xlat_en;
    logic             tbl_wr_en;
    logic [IDX_W-1:0] sw_idx;
    logic [IDX_W-1:0] lk_idx;
    pte_t             sw_wr_pte;
    pte_t             sw_rd_pte;
    pte_t             lk_pte;

    remap_regs #(.APER_BASE(APER_BASE), .SPAN(SPAN), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_off    (reg_off),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xlat_en    (xlat_en),
        .tbl_wr_en  (tbl_wr_en),
        .tbl_idx    (sw_idx),
        .tbl_wr_pte (sw_wr_pte),
        .tbl_rd_pte (sw_rd_pte)
    );

    remap_table #(.PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_idx (sw_idx),
        .wr_pte (sw_wr_pte),
        .ra_idx (sw_idx),
        .ra_pte (sw_rd_pte),
        .rb_idx (lk_idx),
        .rb_pte (lk_pte)
    );

    remap_lookup #(.APER_BASE(APER_BASE), .SPAN(SPAN), .IDX_W(IDX_W)) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .xlat_en    (xlat_en),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .tbl_idx    (lk_idx),
        .tbl_pte    (lk_pte),
        .resp_valid (resp_valid),
        .resp_ok    (resp_ok),
        .resp_fault (resp_fault),
        .resp_addr  (resp_addr)
    );

endmodule

// File: tb/aperture_remap_test.sv
`timescale 1ns/1ps
module aperture_remap_test;

    localparam logic [31:0] BASE  = 32'h0800_0000;
    localparam int          PAGES = 16;
    localparam longint      TOP   = longint'(BASE) + longint'(PAGES) * 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_off = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        resp_valid, resp_ok, resp_fault;
    logic [31:0] resp_addr;

    aperture_remap #(.APER_BASE(BASE), .PAGE_COUNT(PAGES)) uut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .resp_valid(resp_valid),
        .resp_ok(resp_ok), .resp_fault(resp_fault), .resp_addr(resp_addr)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string tag = "R1";

    // behavioural reference
    logic [31:0] m_ent [PAGES];
    logic        m_en;
    logic [31:0] m_ptr;
    logic [31:0] e_rdata;
    logic        e_rv, e_ok, e_fault;
    logic [31:0] e_addr;

    function automatic bit inside_win(logic [31:0] a);
        return (longint'(a) >= longint'(BASE)) && (longint'(a) < TOP);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) m_ent[i] = 32'h0;
            m_en = 1'b0; m_ptr = BASE; e_rdata = 0;
            e_rv = 0; e_ok = 0; e_fault = 0; e_addr = 0;
        end else begin
            e_rv = req_valid; e_ok = 0; e_fault = 0; e_addr = 0;
            if (req_valid) begin
                if (m_en && inside_win(req_addr) &&
                    m_ent[(req_addr - BASE) / 4096][31]) begin
                    e_ok   = 1;
                    e_addr = (m_ent[(req_addr - BASE) / 4096] & 32'h7FFF_F000) |
                             (req_addr & 32'h0000_0FFF);
                end else begin
                    e_fault = 1;
                end
            end
            if (reg_en && !reg_we) begin
                if (reg_off == 4'h0)      e_rdata = {31'h0, m_en};
                else if (reg_off == 4'h4) e_rdata = m_ptr;
                else if (reg_off == 4'h8) e_rdata = m_ent[(m_ptr - BASE) / 4096];
                else                      e_rdata = 0;
            end
            if (reg_en && reg_we) begin
                if (reg_off == 4'h0) m_en = reg_wdata[0];
                else if (reg_off == 4'h4 && inside_win(reg_wdata)) m_ptr = reg_wdata;
                else if (reg_off == 4'h8)
                    m_ent[(m_ptr - BASE) / 4096] = reg_wdata & 32'hFFFF_F000;
            end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("reg_rdata", reg_rdata, e_rdata);
            chk("resp_valid", 32'(resp_valid), 32'(e_rv));
            chk("resp_ok", 32'(resp_ok), 32'(e_ok));
            chk("resp_fault", 32'(resp_fault), 32'(e_fault));
            chk("resp_addr", resp_addr, e_addr);
        end
    end

    task automatic cyc(bit en, bit we, logic [3:0] off, logic [31:0] d,
                       bit rv, logic [31:0] ra);
        @(negedge clk);
        reg_en = en; reg_we = we; reg_off = off; reg_wdata = d;
        req_valid = rv; req_addr = ra;
    endtask

    task automatic idle();
        cyc(0, 0, 4'h0, 32'h0, 0, 32'h0);
    endtask

    task automatic wr(logic [3:0] off, logic [31:0] d);
        cyc(1, 1, off, d, 0, 32'h0);
    endtask

    task automatic rd(logic [3:0] off);
        cyc(1, 0, off, 32'h0, 0, 32'h0);
    endtask

    task automatic look(logic [31:0] a);
        cyc(0, 0, 4'h0, 32'h0, 1, a);
    endtask

    task automatic map_page(int p, logic [31:0] v);
        wr(4'h4, BASE + 32'(p) * 4096);
        wr(4'h8, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        tag = "R1";
        rd(4'h0); rd(4'h4); rd(4'h8); look(BASE); look(BASE + 32'h5000); idle();

        tag = "R2";
        wr(4'h0, 32'h1); rd(4'h0); wr(4'h0, 32'h0); rd(4'h0);
        wr(4'h0, 32'hFFFF_FFF3); rd(4'h0); wr(4'h0, 32'h2); rd(4'h0); idle();

        tag = "R3";
        wr(4'h4, BASE + 32'h3010); rd(4'h4);
        wr(4'h4, BASE - 32'h4); rd(4'h4);
        wr(4'h4, BASE + 32'h1_0000); rd(4'h4);
        wr(4'h4, BASE + 32'hFFFF); rd(4'h4); idle();

        tag = "R4";
        wr(4'h4, BASE + 32'h3010); wr(4'h8, 32'h8001_2FFF); rd(4'h8);
        map_page(0, 32'h8765_4321); rd(4'h8);
        map_page(15, 32'hFFFF_FFFF); rd(4'h8);
        map_page(7, 32'h0123_4000); rd(4'h8); idle();

        tag = "R5";
        map_page(3, 32'h0); rd(4'h8);
        wr(4'h0, 32'h1); look(BASE + 32'h3ABC); idle();

        tag = "R6";
        map_page(2, 32'h8000_5000); map_page(9, 32'h8ABC_D000);
        look(BASE + 32'h2000); look(BASE + 32'h2FFF); look(BASE + 32'h9123);
        look(BASE); look(BASE + 32'hFFFF); idle(); idle();
        for (int i = 0; i < 48; i++) begin
            map_page(i % PAGES, 32'h8000_0000 | (32'(i * 37 + 5) << 12));
            look(BASE + 32'(((i * 5) % PAGES) * 4096 + (i * 91) % 4096));
        end
        idle();

        tag = "R7";
        look(BASE - 32'h1); look(32'h0); look(32'hFFFF_FFFF);
        look(BASE + 32'h1_0000); look(BASE + 32'h1_0FFF); idle();

        tag = "R8";
        map_page(4, 32'h0005_5000); look(BASE + 32'h4010);
        map_page(5, 32'h8006_6000); look(BASE + 32'h5020);
        wr(4'h0, 32'h0); look(BASE + 32'h5020); look(BASE + 32'h2000);
        wr(4'h0, 32'h1); look(BASE + 32'h5020); idle();

        tag = "R9";
        map_page(6, 32'h8011_1000);
        cyc(1, 1, 4'h8, 32'h8022_2000, 1, BASE + 32'h6044);
        look(BASE + 32'h6044);
        cyc(1, 1, 4'h8, 32'h0, 1, BASE + 32'h6FF0);
        look(BASE + 32'h6FF0);
        cyc(1, 1, 4'h8, 32'h8033_3000, 1, BASE + 32'h6001);
        look(BASE + 32'h6001); idle();

        tag = "R10";
        rd(4'h4); idle(); idle(); look(BASE + 32'h6000); idle();
        wr(4'hC, 32'hFFFF_FFFF); rd(4'hC); rd(4'h0);
        wr(4'h2, 32'h0); rd(4'h0); rd(4'h6); rd(4'h8); idle(); idle();

        cmp_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule